// File: doc/BRIEF.md
# Flash Page-Program Command Sequencer

This block turns a stream of single-cycle CPU bus writes into operations on a small nonvolatile array model. A command is a short chain of unlock writes, each with a fixed address and data pair, followed by a command code. Page programming then takes a page address and one page of 32-bit data words. Each word is ANDed into the addressed cell, so programming can only clear bits. A page erase puts a page back to all ones. The array is a register file of `NUM_PAGES` pages of 64 words. Each page is 256 bytes: byte-address bits [8 +: log2(NUM_PAGES)] select the page and bits [7:2] select the word. The array and its per-page "programmed" marks have no reset, so their contents are undefined until a page is erased.

States: `ST_READ` is read mode. It moves to `ST_UNL1` on (0x5AA, 0xAA). `ST_UNL1` moves to `ST_UNL2` on (0xAAA, 0x55). `ST_UNL2` moves on a write to 0x5AA: data 0xA0 goes to `ST_PG_ADDR`, 0x80 goes to `ST_ER_UNL1`, and 0xF0 (software reset) goes back to `ST_READ`. `ST_PG_ADDR` latches the page. It goes to `ST_PG_DATA`, or back to `ST_READ` with the error flag set if the page is already marked programmed. `ST_PG_DATA` stores 64 words and then goes to `ST_WAIT`. `ST_ER_UNL1` (0x5AA, 0xAA) leads to `ST_ER_UNL2`. `ST_ER_UNL2` (0xAAA, 0x55) leads to `ST_ER_CODE`. `ST_ER_CODE` takes data 0x30 and its address page, then goes to `ST_WAIT`. `ST_WAIT` holds for `OP_CYCLES` cycles and then returns to `ST_READ`. A write that does not match what its state expects returns the machine to `ST_READ`. Hardware reset (`rst_n` low) returns it to `ST_READ` from any state.

Top module: `flash_pgm_seq`

## Requirements
- R1: After hardware reset, `ready`=1, `prog_err`=0 and `bus_rdata`=0.
- R2: Only the byte-address and data-byte pairs (0x5AA,0xAA), (0xAAA,0x55), (0x5AA,0xA0) arm page programming, and `ready` drops to 0 in the cycle after the third write.
- R3: Once armed, the fourth write picks the page from its address; its data is ignored. Writes 5 to 68 store words 0 to 63 of that page in order, whatever their addresses.
- R4: A stored word becomes old AND new, so no bit ever goes from 0 to 1 by programming.
- R5: After the last data word, and after the erase code, `ready` stays 0 for exactly `OP_CYCLES` cycles and then returns to 1.
- R6: A read (`bus_re`) returns its data one cycle later. In a ready state the data is the addressed array word. While busy it is the status word: bit 0 = `ready`, bit 1 = `prog_err`, all other bits 0.
- R7: Writes during the busy wait are ignored: no command is armed by them.
- R8: Arming a page that is already marked programmed sets `prog_err`, leaves the array unchanged and returns at once to read mode with `ready`=1.
- R9: The sequence (0x5AA,0xAA), (0xAAA,0x55), (0x5AA,0x80), (0x5AA,0xAA), (0xAAA,0x55), then data 0x30 at any address in a page, clears `prog_err`. When the wait ends, that page is set to 0xFFFFFFFF and its programmed mark is cleared.
- R10: A write that does not match the expected unlock pair returns the sequencer to read mode without arming anything.
- R11: Data 0xF0 at 0x5AA as the third write returns the sequencer to read mode and changes nothing.
- R12: Hardware reset during data collection abandons the operation. Words already stored keep their new value, the rest of the page is unchanged, and the page is not marked, so it can be programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_re | input | 1 | One-cycle bus read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data; the low byte carries command codes |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| ready | output | 1 | 1 when idle, 0 while an operation is in progress |
| prog_err | output | 1 | Set by a second program of a page without an erase in between |

## Verification
The assertions take for granted that a write strobe lasts a single cycle and that all addresses fall inside the modelled array. They also assume that every page is erased before it is first programmed, since marks and contents are undefined until then. The stimulus drives each write for exactly one cycle with an idle cycle after it, builds every address from a page index below `NUM_PAGES`, and erases all pages before any program command. Expected array contents are kept in a bench model and updated by applying AND for programming and all ones for erasure.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PG_ADDR,
        ST_PG_DATA,
        ST_ER_UNL1,
        ST_ER_UNL2,
        ST_ER_CODE,
        ST_WAIT
    } seq_state_t;

    localparam logic [11:0] UNLK_ADDR_A = 12'h5AA;
    localparam logic [11:0] UNLK_ADDR_B = 12'hAAA;
    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  CODE_PROG   = 8'hA0;
    localparam logic [7:0]  CODE_ERASE  = 8'h80;
    localparam logic [7:0]  CODE_SWRST  = 8'hF0;
    localparam logic [7:0]  CODE_PGERS  = 8'h30;

    localparam int PAGE_BYTES = 256;

endpackage

// File: rtl/fseq_array.sv
module fseq_array #(
    parameter int NUM_PAGES = 4,
    parameter int WORDS     = 64,
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int WD_W     = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_page,
    input  logic [WD_W-1:0] wr_word,
    input  logic [31:0]     wr_data,
    input  logic            mark_en,
    input  logic            ers_en,
    input  logic [PG_W-1:0] ers_page,
    input  logic [PG_W-1:0] q_page,
    output logic            q_marked,
    input  logic [PG_W-1:0] rd_page,
    input  logic [WD_W-1:0] rd_word,
    output logic [31:0]     rd_data
);

    logic [31:0]          cell_q [NUM_PAGES*WORDS];
    logic [NUM_PAGES-1:0] marked_q;

    // Nonvolatile model: no reset on cells or marks.
    always_ff @(posedge clk) begin
        if (wr_en)
            cell_q[{wr_page, wr_word}] <= cell_q[{wr_page, wr_word}] & wr_data;
        if (ers_en)
            for (int i = 0; i < WORDS; i++)
                cell_q[{ers_page, WD_W'(i)}] <= '1;
    end

    always_ff @(posedge clk) begin
        if (ers_en)
            marked_q[ers_page] <= 1'b0;
        else if (mark_en)
            marked_q[wr_page] <= 1'b1;
    end

    assign q_marked = marked_q[q_page];
    assign rd_data  = cell_q[{rd_page, rd_word}];

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PAGES = 4,
    parameter int WORDS     = 64,
    parameter int OP_CYCLES = 16,
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int WD_W     = $clog2(WORDS),
    localparam int CNT_W    = $clog2(OP_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              page_marked,
    output logic              ready,
    output logic              err,
    output logic              mem_we,
    output logic [PG_W-1:0]   mem_page,
    output logic [WD_W-1:0]   mem_word,
    output logic [31:0]       mem_data,
    output logic              mark_go,
    output logic              ers_go,
    output logic [PG_W-1:0]   addr_page
);

    seq_state_t       state_q, state_d;
    logic [PG_W-1:0]  pg_q, pg_d;
    logic [WD_W-1:0]  wd_q, wd_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ers_q, ers_d;
    logic             err_q, err_d;
    logic [11:0]      cmd_addr;
    logic [7:0]       cmd_byte;

    assign cmd_addr  = addr[11:0];
    assign cmd_byte  = wdata[7:0];
    assign addr_page = addr[8 +: PG_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            pg_q    <= '0;
            wd_q    <= '0;
            cnt_q   <= '0;
            ers_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pg_q    <= pg_d;
            wd_q    <= wd_d;
            cnt_q   <= cnt_d;
            ers_q   <= ers_d;
            err_q   <= err_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pg_d    = pg_q;
        wd_d    = wd_q;
        cnt_d   = cnt_q;
        ers_d   = ers_q;
        err_d   = err_q;
        unique case (state_q)
            ST_READ:
                if (we && cmd_addr == UNLK_ADDR_A && cmd_byte == KEY_FIRST)
                    state_d = ST_UNL1;
            ST_UNL1:
                if (we)
                    state_d = (cmd_addr == UNLK_ADDR_B && cmd_byte == KEY_SECOND)
                              ? ST_UNL2 : ST_READ;
            ST_UNL2:
                if (we) begin
                    state_d = ST_READ;
                    if (cmd_addr == UNLK_ADDR_A) begin
                        if (cmd_byte == CODE_PROG) begin
                            state_d = ST_PG_ADDR;
                            err_d   = 1'b0;
                        end else if (cmd_byte == CODE_ERASE) begin
                            state_d = ST_ER_UNL1;
                        end
                    end
                end
            ST_PG_ADDR:
                if (we) begin
                    pg_d = addr_page;
                    wd_d = '0;
                    if (page_marked) begin
                        err_d   = 1'b1;
                        state_d = ST_READ;
                    end else begin
                        state_d = ST_PG_DATA;
                    end
                end
            ST_PG_DATA:
                if (we) begin
                    wd_d = wd_q + 1'b1;
                    if (wd_q == WD_W'(WORDS - 1)) begin
                        state_d = ST_WAIT;
                        cnt_d   = CNT_W'(OP_CYCLES - 1);
                        ers_d   = 1'b0;
                    end
                end
            ST_ER_UNL1:
                if (we)
                    state_d = (cmd_addr == UNLK_ADDR_A && cmd_byte == KEY_FIRST)
                              ? ST_ER_UNL2 : ST_READ;
            ST_ER_UNL2:
                if (we)
                    state_d = (cmd_addr == UNLK_ADDR_B && cmd_byte == KEY_SECOND)
                              ? ST_ER_CODE : ST_READ;
            ST_ER_CODE:
                if (we) begin
                    if (cmd_byte == CODE_PGERS) begin
                        pg_d    = addr_page;
                        ers_d   = 1'b1;
                        err_d   = 1'b0;
                        cnt_d   = CNT_W'(OP_CYCLES - 1);
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            ST_WAIT:
                if (cnt_q == '0)
                    state_d = ST_READ;
                else
                    cnt_d = cnt_q - 1'b1;
            default:
                state_d = ST_READ;
        endcase
    end

    // Outputs
    always_comb begin
        ready    = !(state_q inside {ST_PG_ADDR, ST_PG_DATA, ST_WAIT});
        err      = err_q;
        mem_we   = (state_q == ST_PG_DATA) && we;
        mark_go  = mem_we && (wd_q == WD_W'(WORDS - 1));
        ers_go   = (state_q == ST_WAIT) && (cnt_q == '0) && ers_q;
        mem_page = pg_q;
        mem_word = wd_q;
        mem_data = wdata;
    end

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq #(
    parameter int ADDR_W    = 12,
    parameter int NUM_PAGES = 4,
    parameter int OP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ready,
    output logic              prog_err
);

    localparam int WORDS = fseq_pkg::PAGE_BYTES / 4;
    localparam int PG_W  = $clog2(NUM_PAGES);
    localparam int WD_W  = $clog2(WORDS);

    logic            mem_we, mark_go, ers_go, page_marked;
    logic [PG_W-1:0] mem_page, addr_page;
    logic [WD_W-1:0] mem_word;
    logic [31:0]     mem_data, rd_word;

    fseq_ctrl #(
        .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .WORDS(WORDS), .OP_CYCLES(OP_CYCLES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .page_marked(page_marked), .ready(ready), .err(prog_err),
        .mem_we(mem_we), .mem_page(mem_page), .mem_word(mem_word), .mem_data(mem_data),
        .mark_go(mark_go), .ers_go(ers_go), .addr_page(addr_page)
    );

    fseq_array #(.NUM_PAGES(NUM_PAGES), .WORDS(WORDS)) array_i (
        .clk(clk), .wr_en(mem_we), .wr_page(mem_page), .wr_word(mem_word),
        .wr_data(mem_data), .mark_en(mark_go), .ers_en(ers_go), .ers_page(mem_page),
        .q_page(addr_page), .q_marked(page_marked),
        .rd_page(bus_addr[8 +: PG_W]), .rd_word(bus_addr[7:2]), .rd_data(rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= ready ? rd_word : {30'b0, prog_err, ready};
    end

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic        bus_re,
    input logic [31:0] bus_rdata,
    input logic        ready,
    input logic        prog_err,
    input logic        mem_we,
    input logic        ers_go
);

    // R5: busy only begins in response to a bus write
    a_r5_fall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(bus_we));

    // R6: a read while busy yields status with bit 0 clear
    a_r6_busy_read_status: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !ready) |=> (bus_rdata[0] == 1'b0));

    // R3: cells are written only by a bus write while busy
    a_r3_store_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!ready && bus_we));

    // R9: erase commits only at the end of a busy wait
    a_r9_erase_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |-> !ready);

    // R8: a refused program returns to ready without writing
    a_r8_err_returns_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> (ready && !mem_we));

endmodule

bind flash_pgm_seq fseq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .ready(ready), .prog_err(prog_err),
    .mem_we(mem_we), .ers_go(ers_go)
);

// File: tb/flash_pgm_seq_tb.sv
module flash_pgm_seq_tb_top;

    localparam int OPC   = 16;
    localparam int NPG   = 4;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ready, prog_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] model [NPG][WORDS];

    flash_pgm_seq #(.ADDR_W(12), .NUM_PAGES(NPG), .OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ready(ready), .prog_err(prog_err)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int p, int i, int s);
        return {8'(s * 37 + 5), 8'(p * 19 + 3), 8'(i), 8'(~(i * 3))};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic unlock();
        wr(12'h5AA, 32'hAA);
        wr(12'hAAA, 32'h55);
    endtask

    task automatic arm_page(int p);
        unlock();
        wr(12'h5AA, 32'hA0);
        check(ready == 1'b0, "R2 armed", 32'(ready), 32'd0);
        wr(12'(p << 8), 32'h0);
    endtask

    task automatic send_words(int p, int s, int n);
        for (int i = 0; i < n; i++) begin
            wr(12'h000, pat(p, i, s));
            model[p][i] = model[p][i] & pat(p, i, s);
        end
    endtask

    task automatic erase_cmd(int p);
        unlock();
        wr(12'h5AA, 32'h80);
        unlock();
        wr(12'(p << 8) | 12'h04C, 32'h30);
        for (int i = 0; i < WORDS; i++) model[p][i] = '1;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 200 && !ready; k++) @(negedge clk);
    endtask

    task automatic busy_window(string req);
        check(ready == 1'b0, req, 32'(ready), 32'd0);
        repeat (OPC - 1) begin
            @(negedge clk);
            check(ready == 1'b0, req, 32'(ready), 32'd0);
        end
        @(negedge clk);
        check(ready == 1'b1, req, 32'(ready), 32'd1);
    endtask

    task automatic verify_page(int p, string req);
        logic [31:0] d;
        for (int i = 0; i < WORDS; i++) begin
            rd(12'((p << 8) | (i << 2)), d);
            check(d === model[p][i], req, d, model[p][i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1
        check(ready == 1'b1, "R1 ready", 32'(ready), 32'd1);
        check(prog_err == 1'b0, "R1 err", 32'(prog_err), 32'd0);
        check(bus_rdata == 32'd0, "R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;

        // R9 + R5: erase every page, timing on the first
        erase_cmd(0);
        busy_window("R5 erase window");
        for (int p = 1; p < NPG; p++) begin
            erase_cmd(p);
            wait_ready();
        end
        for (int p = 0; p < NPG; p++) verify_page(p, "R9 erased ones");

        // R3 / R5: program all pages
        for (int p = 0; p < NPG; p++) begin
            arm_page(p);
            send_words(p, 1, WORDS);
            if (p == 0) busy_window("R5 program window");
            else if (p == 3) begin
                rd(12'h300, d);
                check(d == 32'h0, "R6 busy status", d, 32'h0);
                wait_ready();
            end else wait_ready();
        end
        for (int p = 0; p < NPG; p++) verify_page(p, "R3 R6 page data");

        // R8: second program refused
        arm_page(1);
        check(ready == 1'b1, "R8 ready", 32'(ready), 32'd1);
        check(prog_err == 1'b1, "R8 err", 32'(prog_err), 32'd1);
        verify_page(1, "R8 unchanged");

        // R7: commands during erase wait are ignored; R9 clears err
        erase_cmd(2);
        check(prog_err == 1'b0, "R9 err cleared", 32'(prog_err), 32'd0);
        unlock();
        wr(12'h5AA, 32'hA0);
        check(ready == 1'b0, "R7 still busy", 32'(ready), 32'd0);
        wait_ready();
        repeat (4) begin
            @(negedge clk);
            check(ready == 1'b1, "R7 nothing armed", 32'(ready), 32'd1);
        end
        verify_page(2, "R7 R9 erased");

        // R10: wrong second unlock address
        wr(12'h5AA, 32'hAA);
        wr(12'h5AA, 32'h55);
        wr(12'h5AA, 32'hA0);
        check(ready == 1'b1, "R10 not armed", 32'(ready), 32'd1);
        wr(12'h200, 32'h0);
        for (int i = 0; i < 3; i++) wr(12'h000, 32'h0);
        check(ready == 1'b1, "R10 still read", 32'(ready), 32'd1);
        verify_page(2, "R10 unchanged");

        // R11: software reset
        unlock();
        wr(12'h5AA, 32'hF0);
        check(ready == 1'b1, "R11 ready", 32'(ready), 32'd1);
        wr(12'h200, 32'h0);
        wr(12'h000, 32'h0);
        check(ready == 1'b1, "R11 read mode", 32'(ready), 32'd1);
        verify_page(2, "R11 unchanged");

        // R12: hardware reset mid-page on erased page 1
        erase_cmd(1);
        wait_ready();
        arm_page(1);
        send_words(1, 3, 10);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(ready == 1'b1, "R12 ready", 32'(ready), 32'd1);
        check(prog_err == 1'b0, "R12 err", 32'(prog_err), 32'd0);
        verify_page(1, "R12 partial");

        // R4: reprogram same page, AND with partial words
        arm_page(1);
        check(prog_err == 1'b0, "R12 not marked", 32'(prog_err), 32'd0);
        send_words(1, 4, WORDS);
        wait_ready();
        verify_page(1, "R4 and merge");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule